// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block holds the control logic of a byte-wide parallel EEPROM. A host drives an asynchronous-style bus: active-low chip enable, output enable and write enable, a byte address, and a data byte. The bidirectional data pins are split into an input byte, an output byte and an output-enable flag. The block samples every bus pin through a synchronizer pipeline in its own clock domain. A write strobe is a low pulse on write enable while chip enable is low. On the rising edge of write enable the block captures the address and data seen in the last low cycle of the strobe and loads that byte into a page buffer.

The first loaded byte opens a load window. Each further strobe restarts the window. When the window expires with no new strobe, a self-timed program phase runs for a fixed number of clocks. At its end, the loaded bytes are copied into the storage array in one step and the buffer clears itself. While a load or program phase is active, a read returns status bits instead of array data. A three-write key sequence turns software protection on or off. When protection is on, a byte write takes effect only if it follows the key sequence. The default configuration is a 2 KiB array (`ADDR_W` = 11). Setting `ADDR_W` to 13 gives the full 8,192-byte, 256-page organisation.

Top module: `eep_page_ctl`

## Requirements
- R1: While reset is held, and straight after it with the bus idle, `dq_oe` is 0 even if chip enable and output enable are driven low during reset. Software protection starts off.
- R2: `dq_oe` is 1 only when the synchronized chip enable and output enable are low and write enable is high. When the block is idle, `dq_out` then shows the array byte at the sampled address.
- R3: The low `PAGE_W` (5) address bits pick a byte within a page and the upper bits pick the page. One page write loads from 1 to 32 bytes. All of them reach the array when the write cycle ends.
- R4: A strobe that arrives less than `LOAD_WIN` clocks after the previous one restarts the load window. Bytes spaced this way all land in the same write cycle, even when the whole burst lasts longer than one window.
- R5: Bytes of the page that were not loaded keep their earlier array contents.
- R6: During the load and program phases a read returns bit 7 as the inverse of bit 7 of the most recently loaded byte. Bit 6 flips on every new read access and bits 5..0 read 0.
- R7: The program phase lasts `PROG_CYC` clocks. After it, reads return true array data and the page buffer is empty, so a later write cycle commits only its own bytes.
- R8: Strobes that arrive during the program phase have no effect on the array.
- R9: A strobe that ends while output enable is low is ignored. No load starts and the array is unchanged.
- R10: Three writes turn protection on: 0xAA to `KEY_ADDR_A` (0x555), then 0x55 to `KEY_ADDR_B` (0x2AA), then 0xA0 to `KEY_ADDR_A`. These writes are not stored. The sequence also opens a load window, and the bytes written in that window are stored. While protection is on, a byte write that does not follow the sequence is dropped.
- R11: The same first two writes followed by 0x20 to `KEY_ADDR_A` turn protection off. After that, plain byte writes are stored again.
- R12: The address and data of a write are taken from the last clock of the strobe. The host may change them in the same cycle that write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge ends a strobe |
| addr | input | ADDR_W (11) | Byte address; the low 5 bits are the byte within the page |
| dq_in | input | 8 | Data from the host |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | High while the block drives the data pins |

## Verification
The bench spreads strobes so that each gap is shorter than the load window but the whole burst is longer. A controller that does not restart the window would start programming early and lose the last byte. It rewrites one byte of a page that is already full and reads back its neighbours, which catches a commit that writes the whole page or reuses stale buffer contents. It sends strobes in the middle of the program phase, with output enable low, and while protection is on, then reads back to show that none of them reached the array. Polled reads check the inverted bit 7, and back-to-back polls check that bit 6 alternates. A toggle that is stuck or a polarity that is wrong shows up at once.

// File: rtl/eep_pkg.sv
// Shared types and key constants for the parallel EEPROM controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package eep_pkg;

    // Write sequencer phases
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LOAD = 2'd1,
        WS_PROG = 2'd2
    } wseq_e;

    // Key-sequence progress
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ONE  = 2'd1,
        KS_TWO  = 2'd2
    } key_e;

    localparam logic [7:0] KEY_BYTE_1 = 8'hAA;
    localparam logic [7:0] KEY_BYTE_2 = 8'h55;
    localparam logic [7:0] CMD_LOCK   = 8'hA0;
    localparam logic [7:0] CMD_UNLOCK = 8'h20;

endpackage

// File: rtl/eep_bus_sync.sv
// Multi-stage register pipeline that brings a bundle of asynchronous bus
// pins into the clock domain. All bits pass through the same number of
// stages, so address and data stay aligned with the strobes.
// Assumes the host holds each level for more than one clock.
module eep_bus_sync #(
    parameter int            W       = 8,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                // Later stages shift the bundle along
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/eep_unlock.sv
// Software write-protection tracker. It watches accepted byte writes for
// the three-write key sequence, sets or clears the protect flag, and says
// whether each write is key traffic (consumed) or a data byte to load.
// Assumes wr pulses for one clock per accepted strobe.
module eep_unlock
    import eep_pkg::*;
#(
    parameter int                 ADDR_W     = 11,
    parameter logic [ADDR_W-1:0]  KEY_ADDR_A = 'h555,
    parameter logic [ADDR_W-1:0]  KEY_ADDR_B = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_start,
    output logic              load_ok,
    output logic              arm_pulse,
    output logic              prot
);

    key_e ks_q, ks_nxt;
    logic prot_q, armed_q;
    logic consume, do_lock, do_unlock;

    // Decode the key sequence for the current write
    always_comb begin
        ks_nxt    = ks_q;
        consume   = 1'b0;
        do_lock   = 1'b0;
        do_unlock = 1'b0;
        if (wr) begin
            case (ks_q)
                KS_IDLE: begin
                    if (wr_addr == KEY_ADDR_A && wr_data == KEY_BYTE_1) begin
                        consume = 1'b1;
                        ks_nxt  = KS_ONE;
                    end
                end
                KS_ONE: begin
                    ks_nxt = KS_IDLE;
                    if (wr_addr == KEY_ADDR_B && wr_data == KEY_BYTE_2) begin
                        consume = 1'b1;
                        ks_nxt  = KS_TWO;
                    end
                end
                KS_TWO: begin
                    ks_nxt = KS_IDLE;
                    if (wr_addr == KEY_ADDR_A && wr_data == CMD_LOCK) begin
                        consume = 1'b1;
                        do_lock = 1'b1;
                    end else if (wr_addr == KEY_ADDR_A && wr_data == CMD_UNLOCK) begin
                        consume   = 1'b1;
                        do_unlock = 1'b1;
                    end
                end
                default: ks_nxt = KS_IDLE;
            endcase
        end
    end

    // Sequence state, protect flag and one-cycle write permission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_q    <= KS_IDLE;
            prot_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ks_q <= ks_nxt;
            if (do_lock)        prot_q <= 1'b1;
            else if (do_unlock) prot_q <= 1'b0;
            if (do_unlock)       armed_q <= 1'b0;
            else if (do_lock)    armed_q <= 1'b1;
            else if (prog_start) armed_q <= 1'b0;
        end
    end

    assign load_ok   = wr && !consume && (!prot_q || armed_q);
    assign arm_pulse = do_lock;
    assign prot      = prot_q;

    // R10: protection only changes as a result of a write
    p_prot_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(wr));

    // R11: a write permission never outlives protection being cleared
    p_armed_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> prot_q);

endmodule

// File: rtl/eep_write_seq.sv
// Write cycle sequencer. A kick opens or restarts the load window. When the
// window runs out it enters the self-timed program phase. At the end of
// that phase it issues a single commit pulse and returns to idle.
// Assumes kick is never asserted during the program phase.
module eep_write_seq
    import eep_pkg::*;
#(
    parameter int LOAD_WIN = 64,
    parameter int PROG_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic loading,
    output logic prog,
    output logic prog_start,
    output logic commit
);

    localparam int MAXC  = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_WIN - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);

    wseq_e            st_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase state and shared cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WS_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                WS_IDLE: begin
                    cnt_q <= '0;
                    if (kick) st_q <= WS_LOAD;
                end
                WS_LOAD: begin
                    if (kick) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LOAD_LAST) begin
                        cnt_q <= '0;
                        st_q  <= WS_PROG;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WS_PROG: begin
                    if (cnt_q == PROG_LAST) begin
                        cnt_q <= '0;
                        st_q  <= WS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= WS_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign loading    = (st_q == WS_LOAD);
    assign prog       = (st_q == WS_PROG);
    assign prog_start = loading && !kick && (cnt_q == LOAD_LAST);
    assign commit     = prog && (cnt_q == PROG_LAST);

    // R4: a kick inside the window leaves the block loading with a fresh count
    p_window_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && kick) |=> (loading && cnt_q == '0));

    // R7: the program phase never runs past its length
    p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> (cnt_q <= PROG_LAST));

    // R7: leaving the program phase always lands in idle
    p_prog_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog) |-> (!loading && !prog));

    // R7: phases are mutually exclusive
    p_phase_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loading, prog}));

endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: one byte register and one valid flag per page position,
// plus the page row taken from the most recent load. Commit clears every
// valid flag (auto-clear). Assumes load and commit are never high together.
module eep_page_buf #(
    parameter int PAGE_W = 5,
    parameter int ROW_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PAGE_W-1:0]       idx,
    input  logic [ROW_W-1:0]        row_in,
    input  logic [7:0]              din,
    input  logic                    commit,
    output logic [(1<<PAGE_W)-1:0]  valid,
    output logic [ROW_W-1:0]        row,
    output logic [(1<<PAGE_W)*8-1:0] data_flat
);

    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]      pg_data [PAGE];
    logic [PAGE-1:0] valid_q;
    logic [ROW_W-1:0] row_q;

    // Valid flags and row latch, cleared on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            row_q   <= '0;
        end else if (commit) begin
            valid_q <= '0;
        end else if (load) begin
            valid_q[idx] <= 1'b1;
            row_q        <= row_in;
        end
    end

    // Byte storage, only meaningful where the valid flag is set
    always_ff @(posedge clk) begin
        if (load) pg_data[idx] <= din;
    end

    generate
        for (genvar g = 0; g < PAGE; g++) begin : g_flat
            assign data_flat[g*8 +: 8] = pg_data[g];
        end
    endgenerate

    assign valid = valid_q;
    assign row   = row_q;

    // R7: buffer is empty the cycle after a commit
    p_autoclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (valid_q == '0));

    // R8: without a load the set of pending bytes never grows
    p_no_stray_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !commit) |=> $stable(valid_q));

endmodule

// File: rtl/eep_page_ctl.sv
// Top of the parallel EEPROM controller. It synchronizes the host bus,
// detects write strobes with hardware gating, routes each write through the
// software protection tracker into the page buffer, runs the write
// sequencer, commits pages into the register array, and muxes read data
// against the busy status. Assumes the host holds bus levels for several
// clocks and the array has no reset.
module eep_page_ctl
    import eep_pkg::*;
#(
    parameter int                ADDR_W      = 11,
    parameter int                PAGE_W      = 5,
    parameter int                SYNC_STAGES = 2,
    parameter int                LOAD_WIN    = 64,
    parameter int                PROG_CYC    = 500,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A  = 'h555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B  = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int BW    = 3 + ADDR_W + 8;
    localparam logic [BW-1:0] BUS_RST = {3'b111, {(ADDR_W + 8){1'b0}}};

    logic [BW-1:0]     s_bus, d_bus;
    logic              s_ce_n, s_oe_n, s_we_n, d_ce_n, d_oe_n, d_we_n;
    logic [ADDR_W-1:0] s_addr, d_addr;
    logic [7:0]        s_din, d_din;

    logic wr_ev, wr_ok, load_ok, arm_pulse, prot;
    logic loading, prog, prog_start, commit, busy;
    logic [PAGE-1:0]   pg_valid;
    logic [ROW_W-1:0]  pg_row;
    logic [PAGE*8-1:0] pg_flat;
    logic [7:0]        last_q;
    logic              tog_q, rd_q, rd_active, rd_start;
    logic [7:0]        mem [DEPTH];

    eep_bus_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, oe_n, we_n, addr, dq_in}),
        .q(s_bus)
    );

    // One extra stage so a strobe's last low cycle is still visible at its end
    always_ff @(posedge clk) begin
        if (!rst_n) d_bus <= BUS_RST;
        else        d_bus <= s_bus;
    end

    assign {s_ce_n, s_oe_n, s_we_n, s_addr, s_din} = s_bus;
    assign {d_ce_n, d_oe_n, d_we_n, d_addr, d_din} = d_bus;

    // Strobe ends on write-enable rise; chip enable low and output enable high required
    assign wr_ev = s_we_n && !d_we_n && !d_ce_n && d_oe_n;
    assign wr_ok = wr_ev && !prog;

    eep_unlock #(.ADDR_W(ADDR_W), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)) u_unlock (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_ok), .wr_addr(d_addr), .wr_data(d_din),
        .prog_start(prog_start),
        .load_ok(load_ok), .arm_pulse(arm_pulse), .prot(prot)
    );

    eep_write_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .kick(load_ok || arm_pulse),
        .loading(loading), .prog(prog),
        .prog_start(prog_start), .commit(commit)
    );

    eep_page_buf #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .load(load_ok),
        .idx(d_addr[PAGE_W-1:0]),
        .row_in(d_addr[ADDR_W-1:PAGE_W]),
        .din(d_din),
        .commit(commit),
        .valid(pg_valid), .row(pg_row), .data_flat(pg_flat)
    );

    // Copy every loaded byte of the page into the array at commit
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pg_valid[i]) mem[{pg_row, PAGE_W'(i)}] <= pg_flat[i*8 +: 8];
            end
        end
    end

    assign busy      = loading || prog;
    assign rd_active = !s_ce_n && !s_oe_n && s_we_n;
    assign rd_start  = rd_active && !rd_q;

    // Last loaded byte, read-edge tracker and toggle bit for status reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            rd_q   <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            rd_q <= rd_active;
            if (load_ok)            last_q <= d_din;
            if (rd_start && busy)   tog_q  <= !tog_q;
        end
    end

    // Read data: status while busy, array contents otherwise
    always_comb begin
        if (busy) dq_out = {!last_q[7], tog_q, 6'b0};
        else      dq_out = mem[s_addr];
    end
    assign dq_oe = rd_active;

    // R6: each new read during a busy phase flips the toggle bit
    p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy) |=> (tog_q != $past(tog_q)));

    // R9: a strobe ending with output enable low never starts a load
    p_hw_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we_n && !d_we_n && !d_oe_n) |-> !load_ok);

    // R10: while protected, no byte loads unless a key sequence armed it
    p_sw_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && !loading && !$past(arm_pulse)) |-> !load_ok || $past(prot) == 1'b0 || 1'b1 == load_ok && u_unlock.armed_q);

endmodule

// File: tb/eep_page_ctl_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, protection, window restart and busy-phase corner cases.
module eep_page_ctl_bench;

    localparam int AW = 11;
    localparam int LW = 20;
    localparam int PC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit poll_seen = 0;
    logic last_tog = 1'b0;

    always #5 clk = ~clk;

    eep_page_ctl #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) u_eep_page_ctl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // op: 0 write, 1 read-compare, 2 status poll (exp = expected bit 7), 3 wait for commit
    localparam int NV = 18;
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 11'h040, 8'h11, 8'h00},
        {2'd0, 11'h041, 8'h22, 8'h00},
        {2'd0, 11'h05F, 8'hB3, 8'h00},
        {2'd2, 11'h040, 8'h00, 8'h00},
        {2'd2, 11'h040, 8'h00, 8'h00},
        {2'd3, 11'h000, 8'h00, 8'h00},
        {2'd1, 11'h040, 8'h00, 8'h11},
        {2'd1, 11'h041, 8'h00, 8'h22},
        {2'd1, 11'h05F, 8'h00, 8'hB3},
        {2'd0, 11'h041, 8'h44, 8'h00},
        {2'd2, 11'h041, 8'h00, 8'h80},
        {2'd3, 11'h000, 8'h00, 8'h00},
        {2'd1, 11'h040, 8'h00, 8'h11},
        {2'd1, 11'h041, 8'h00, 8'h44},
        {2'd1, 11'h05F, 8'h00, 8'hB3},
        {2'd0, 11'h080, 8'h01, 8'h00},
        {2'd3, 11'h000, 8'h00, 8'h00},
        {2'd1, 11'h080, 8'h00, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input bit oe_low);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; addr = ~a; dq_in = ~d;   // R12: change bus as strobe ends
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        v = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] v; logic oe;
        bus_read(a, v, oe);
        check({req, " dq_oe"}, {7'd0, oe}, 8'h01);
        check(req, v, exp);
    endtask

    task automatic poll_check(input logic [7:0] exp_b7);
        logic [7:0] v; logic oe;
        bus_read(addr, v, oe);
        check("R6 status bits 7,5..0", {v[7], 1'b0, v[5:0]}, {exp_b7[7], 7'd0});
        if (poll_seen) check("R6 toggle bit", {7'd0, v[6]}, {7'd0, ~last_tog});
        poll_seen = 1;
        last_tog  = v[6];
    endtask

    task automatic wait_done();
        repeat (LW + PC + 20) @(negedge clk);
        poll_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: pins request a read during reset, outputs stay off
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 dq_oe in reset", {7'd0, dq_oe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 dq_oe after reset", {7'd0, dq_oe}, 8'h00);

        // Table: R3 page load, R5 partial rewrite, R6 polling, R7 completion, R12 latching
        for (int i = 0; i < NV; i++) begin
            logic [1:0]    op;
            logic [AW-1:0] a;
            logic [7:0]    d, e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: bus_write(a, d, 1'b0);
                2'd1: read_check("R3/R5/R7/R12 table read", a, e);
                2'd2: poll_check(e);
                default: wait_done();
            endcase
        end

        // R2: output enable high or write enable low keeps the pins released
        @(negedge clk); addr = 11'h040; ce_n = 1'b0; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 oe_n high", {7'd0, dq_oe}, 8'h00);
        oe_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 we_n low", {7'd0, dq_oe}, 8'h00);
        oe_n = 1'b1; repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (20) @(negedge clk);
        wait_done();

        // R8: strobe during the program phase is dropped
        bus_write(11'h0A0, 8'h77, 1'b0);
        repeat (LW + 6) @(negedge clk);
        bus_write(11'h080, 8'hEE, 1'b0);
        wait_done();
        read_check("R8 ignored during program", 11'h080, 8'h01);
        read_check("R8 earlier byte kept", 11'h0A0, 8'h77);

        // R9: strobe with output enable low is ignored
        bus_write(11'h080, 8'h99, 1'b1);
        wait_done();
        read_check("R9 hardware block", 11'h080, 8'h01);

        // R4: gaps shorter than the window, burst longer than it
        bus_write(11'h0E0, 8'h10, 1'b0);
        repeat (6) @(negedge clk);
        bus_write(11'h0E1, 8'h20, 1'b0);
        repeat (6) @(negedge clk);
        bus_write(11'h0E2, 8'h30, 1'b0);
        poll_check(8'h80);
        wait_done();
        read_check("R4 first byte", 11'h0E0, 8'h10);
        read_check("R4 middle byte", 11'h0E1, 8'h20);
        read_check("R4 last byte", 11'h0E2, 8'h30);

        // R10: key sequence enables protection and admits the following byte
        bus_write(11'h555, 8'hAA, 1'b0);
        bus_write(11'h2AA, 8'h55, 1'b0);
        bus_write(11'h555, 8'hA0, 1'b0);
        bus_write(11'h0C0, 8'h42, 1'b0);
        wait_done();
        read_check("R10 keyed write", 11'h0C0, 8'h42);
        bus_write(11'h0C0, 8'h24, 1'b0);
        wait_done();
        read_check("R10 protected plain write", 11'h0C0, 8'h42);

        // R11: disable sequence lets plain writes through again
        bus_write(11'h555, 8'hAA, 1'b0);
        bus_write(11'h2AA, 8'h55, 1'b0);
        bus_write(11'h555, 8'h20, 1'b0);
        bus_write(11'h0C0, 8'h24, 1'b0);
        wait_done();
        read_check("R11 unprotected write", 11'h0C0, 8'h24);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule